// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block watches a bank of already-synchronized GPIO inputs for transitions and turns them into one shared, level-sensitive interrupt. For every pin, software chooses whether a low-to-high transition, a high-to-low transition, or both should count. A qualifying transition sets that pin's bit in a sticky cause register. A per-pin event mask then decides which of those latched causes may drive the interrupt line.

Software works through a small register bus. Writes take effect on the clock edge at which they are presented. Reads are combinational from the current register state. The interrupt handler reads the masked cause word, services the pins that are set, and then writes ones to a separate clear register to retire them. Pad direction and ownership logic belong to neighbouring blocks.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the rise-enable, fall-enable, event-mask and masked-cause words all read 0, and `irq` is low.
- R2: When bit i of the rise-enable word (address 0x00) is 1 and pin i is sampled 1 one cycle after it was sampled 0, cause bit i sets on that clock edge.
- R3: When bit i of the fall-enable word (address 0x04) is 1 and pin i is sampled 0 one cycle after it was sampled 1, cause bit i sets on that clock edge.
- R4: A pin with both its rise-enable and fall-enable bits set latches a cause on transitions in either direction.
- R5: A transition in a direction whose enable bit is 0 does not set that pin's cause bit, and a cause bit never sets without a qualifying transition.
- R6: Cause bits latch whatever the value of the event-mask word (address 0x08). Reading address 0x0C returns the latched causes ANDed with the event mask.
- R7: `irq` is high exactly when at least one latched cause bit has its event-mask bit set. It follows mask or cause changes with no added register stage.
- R8: Writing the clear word (address 0x10) clears every cause bit written as 1 on that edge. Bits written as 0 keep their value.
- R9: If a qualifying transition on pin i and a clear of bit i occur on the same edge, cause bit i ends up set.
- R10: The enable and mask words read back what was last written. Writes to address 0x0C have no effect. Reads of addresses other than 0x00, 0x04, 0x08 and 0x0C return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Shared level interrupt |

## Verification
Most internal faults show up on the port of the very next cycle. A stale previous-level flop makes phantom or missing causes appear in the 0x0C readback at the edge after the pin changes. A wrong mask or clear decode shows at once on `irq` and in the readback. Lost stickiness only appears later: a cause that drops without a clear is seen on the next read, well before software would clear it. The bench therefore reads the masked cause and samples `irq` on the cycle right after each stimulus edge.

// File: rtl/gpio_irq_pkg.sv
// Package: register map shared by the cause unit and its bench.
// Assumes a byte-addressed bus with one 32-bit-aligned word per register.
package gpio_irq_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_RISE_EN = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_FALL_EN = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_EVT_MSK = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CAUSE   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLEAR   = 8'h10;
endpackage

// File: rtl/gpio_irq_regs.sv
// Module: software-written control words (rise enable, fall enable, event
// mask) and the write-one-to-clear strobe vector.
// Assumes single-cycle writes; the clear vector is valid only in the write cycle.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] rise_en,
    output logic [NUM_PINS-1:0] fall_en,
    output logic [NUM_PINS-1:0] evt_msk,
    output logic [NUM_PINS-1:0] clr_vec
);

    // Control word storage, loaded on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            evt_msk <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_RISE_EN) rise_en <= bus_wdata;
            if (bus_addr == OFS_FALL_EN) fall_en <= bus_wdata;
            if (bus_addr == OFS_EVT_MSK) evt_msk <= bus_wdata;
        end
    end

    // Decode the clear strobe: write data passes only on a clear-register write.
    always_comb begin
        clr_vec = (bus_wr && bus_addr == OFS_CLEAR) ? bus_wdata : '0;
    end

endmodule

// File: rtl/gpio_edge_detect.sv
// Module: per-pin transition detector. Compares each synchronized pin with
// its level one cycle earlier and qualifies by the rise/fall enables.
// Assumes pin_in is already synchronized to clk; the previous level resets to 0.
module gpio_edge_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    output logic [NUM_PINS-1:0] pin_prev,
    output logic [NUM_PINS-1:0] edge_hit
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // Remember the level seen on the previous edge.
        always_ff @(posedge clk) begin
            if (!rst_n) pin_prev[g] <= 1'b0;
            else        pin_prev[g] <= pin_in[g];
        end

        // Flag an enabled transition in either direction.
        always_comb begin
            edge_hit[g] = (rise_en[g] &  pin_in[g] & ~pin_prev[g])
                        | (fall_en[g] & ~pin_in[g] &  pin_prev[g]);
        end
    end

endmodule

// File: rtl/gpio_cause_reg.sv
// Module: sticky cause bits. A qualifying edge sets a bit and a clear strobe
// resets it; a set on the same edge wins over the clear.
// Assumes edge_hit and clr_vec are both single-cycle pulses.
module gpio_cause_reg #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] edge_hit,
    input  logic [NUM_PINS-1:0] clr_vec,
    output logic [NUM_PINS-1:0] cause_q
);

    // Update causes: drop cleared bits, then OR in new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_vec) | edge_hit;
    end

endmodule

// File: rtl/gpio_edge_irq.sv
// Module: top of the GPIO edge interrupt cause unit. Ties together the
// control registers, the edge detectors and the cause register, and drives
// the read mux and the shared level interrupt.
// Assumes synchronized pins and a combinational read path.
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic                irq
);

    logic [NUM_PINS-1:0] rise_en;
    logic [NUM_PINS-1:0] fall_en;
    logic [NUM_PINS-1:0] evt_msk;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] pin_prev;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] cause_q;
    logic [NUM_PINS-1:0] masked;

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .evt_msk   (evt_msk),
        .clr_vec   (clr_vec)
    );

    gpio_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .pin_prev (pin_prev),
        .edge_hit (edge_hit)
    );

    gpio_cause_reg #(.NUM_PINS(NUM_PINS)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .clr_vec  (clr_vec),
        .cause_q  (cause_q)
    );

    // Apply the event mask; this is both the readback and the interrupt source.
    always_comb begin
        masked = cause_q & evt_msk;
        irq    = |masked;
    end

    // Select read data by address; unmapped words read zero.
    always_comb begin
        case (bus_addr)
            OFS_RISE_EN: bus_rdata = rise_en;
            OFS_FALL_EN: bus_rdata = fall_en;
            OFS_EVT_MSK: bus_rdata = evt_msk;
            OFS_CAUSE:   bus_rdata = masked;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Module: assertion checker for gpio_edge_irq, bound into the top.
// Assumes it sees the internal control, edge and cause vectors.
module gpio_edge_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_in,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic                irq,
    input logic [NUM_PINS-1:0] rise_en,
    input logic [NUM_PINS-1:0] fall_en,
    input logic [NUM_PINS-1:0] pin_prev,
    input logic [NUM_PINS-1:0] edge_hit,
    input logic [NUM_PINS-1:0] cause_q
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq); // R1

    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise_en & pin_in & ~pin_prev) & ~cause_q) == '0)); // R2

    AST_FALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(fall_en & ~pin_in & pin_prev) & ~cause_q) == '0)); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(edge_hit)) == '0)); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLEAR)
        |=> ((cause_q & $past(bus_wdata & ~edge_hit)) == '0)); // R8

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_CLEAR) |=> (($past(cause_q) & ~cause_q) == '0)); // R8

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .pin_prev  (pin_prev),
    .edge_hit  (edge_hit),
    .cause_q   (cause_q)
);

// File: tb/gpio_edge_irq_test.sv
// Scoreboard bench: driver tasks queue expected read items, a monitor
// process pops and compares them on the falling clock edge.
`timescale 1ns/1ps
module gpio_edge_irq_test;
    import gpio_irq_pkg::*;

    localparam int NP = 32;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [NP-1:0]     exp_data;
        logic              exp_irq;
        string             tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     pin_in = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [NP-1:0]     bus_wdata = '0;
    logic [NP-1:0]     bus_rdata;
    logic              irq;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_edge_irq #(.NUM_PINS(NP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Monitor: compare read data and irq against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (bus_rdata !== it.exp_data || irq !== it.exp_irq) begin
                    n_errors++;
                    $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, it.addr, bus_rdata, irq, it.exp_data, it.exp_irq);
                end
            end
        end
    end

    task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [NP-1:0] d,
                            input logic i, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        bus_addr = a;
        it.addr = a; it.exp_data = d; it.exp_irq = i; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [NP-1:0] d);
        @(posedge clk);
        #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(posedge clk);
        #1;
        pin_in = v;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        read_chk(OFS_RISE_EN, '0, 1'b0, "R1 rise enable reset");
        read_chk(OFS_FALL_EN, '0, 1'b0, "R1 fall enable reset");
        read_chk(OFS_EVT_MSK, '0, 1'b0, "R1 mask reset");
        read_chk(OFS_CAUSE,   '0, 1'b0, "R1 cause reset");
        // R10: enables and mask read back
        wr(OFS_RISE_EN, 32'h8000_0005);
        wr(OFS_FALL_EN, 32'h0000_0006);
        wr(OFS_EVT_MSK, 32'hFFFF_FFFF);
        read_chk(OFS_RISE_EN, 32'h8000_0005, 1'b0, "R10 rise readback");
        read_chk(OFS_FALL_EN, 32'h0000_0006, 1'b0, "R10 fall readback");
        // R2, R5: rises on bits 31,3..0; only 31,2,0 rise-enabled
        set_pins(32'h8000_000F);
        read_chk(OFS_CAUSE, 32'h8000_0005, 1'b1, "R2 R5 rising causes");
        // R8: clear bit 0, then a zero write leaves causes alone
        wr(OFS_CLEAR, 32'h0000_0001);
        read_chk(OFS_CAUSE, 32'h8000_0004, 1'b1, "R8 clear one bit");
        wr(OFS_CLEAR, 32'h0000_0000);
        read_chk(OFS_CAUSE, 32'h8000_0004, 1'b1, "R8 zero write no effect");
        // R3, R4: falls on all; bits 1 and 2 fall-enabled, bit 2 on both edges
        set_pins(32'h0000_0000);
        read_chk(OFS_CAUSE, 32'h8000_0006, 1'b1, "R3 R4 falling causes");
        // R7: clear everything drops irq
        wr(OFS_CLEAR, 32'hFFFF_FFFF);
        read_chk(OFS_CAUSE, '0, 1'b0, "R7 irq low after full clear");
        // R6: cause latches while masked, appears once unmasked
        wr(OFS_EVT_MSK, 32'h0000_0000);
        set_pins(32'h0000_0001);
        read_chk(OFS_CAUSE, '0, 1'b0, "R6 masked cause hidden");
        wr(OFS_EVT_MSK, 32'h0000_0001);
        read_chk(OFS_CAUSE, 32'h0000_0001, 1'b1, "R6 R7 unmasked cause visible");
        // R9: rise on bit 2 together with clear of bits 0 and 2
        wr(OFS_EVT_MSK, 32'hFFFF_FFFF);
        @(posedge clk);
        #1;
        pin_in = 32'h0000_0005;
        bus_wr = 1'b1; bus_addr = OFS_CLEAR; bus_wdata = 32'h0000_0005;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_wdata = '0;
        read_chk(OFS_CAUSE, 32'h0000_0004, 1'b1, "R9 edge wins over clear");
        // R10: cause address is read-only, unmapped reads zero
        wr(OFS_CAUSE, 32'hFFFF_FFFF);
        read_chk(OFS_CAUSE, 32'h0000_0004, 1'b1, "R10 cause write ignored");
        read_chk(8'h1C, '0, 1'b1, "R10 unmapped read zero");
        // R7: mask off the only cause
        wr(OFS_EVT_MSK, 32'hFFFF_FFFB);
        read_chk(OFS_CAUSE, '0, 1'b0, "R7 irq follows mask");
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule